// File: doc/BRIEF.md
# Twenty-four channel GPIO with phase-locked pulse outputs

This block is a bank of 24 general-purpose pins. Software sets each pin as an input or an output through a small register port. The pad tristate cells sit outside the block, so it presents separate output, output-enable and input vectors. Every input is resynchronised through two flops before software can read it.

The lowest eight channels can also be switched into pulse mode. A single shared 20-bit down-counter times one active-high pulse. Every channel taking part goes high on the same cycle and returns low on the same cycle. When software writes the start command, the counter is loaded with the programmed length N, and the chosen channels stay high for exactly N clock cycles. Pulses out of phase with each other cannot be produced by construction.

Register map on `bus_addr` (writes happen on `bus_we`, reads are combinational on `bus_rdata`):
- 0: direction, bits [23:0], 1 = output.
- 1: output value, bits [23:0].
- 2: input readback, bits [23:0], read-only.
- 3: pulse select, bits [7:0], for channels 7..0.
- 4: pulse length, bits [19:0].
- 5: command. A write with bit 0 = 1 starts a pulse. A read returns busy in bit 0.
- Unused bits and addresses read as zero.

Top module: `gpio_pulse24`

## Requirements
- R1: After reset, the direction, output value, pulse select and pulse length registers are all zero. `pad_oe` and `pad_out` are all zero, and busy (address 5, bit 0) reads 0.
- R2: A channel that is not in pulse mode drives `pad_oe` from its direction bit (address 0) and `pad_out` from its output value bit (address 1). Both registers read back as written.
- R3: Input readback (address 2) shows `pad_in` after exactly two rising clock edges: not after one edge, and the value is present after the second.
- R4: A write of bit 0 = 1 to address 5 with length N > 0 and no pulse running makes the selected channels high from the clock edge of that write for exactly N cycles. Busy is 1 for those same cycles.
- R5: All channels taking part in a pulse rise on the same cycle and fall on the same cycle.
- R6: A start command while busy is 1 is ignored. The running pulse keeps its original end cycle, even if the length register is rewritten during the pulse.
- R7: A start command with length 0 produces no pulse, and busy stays 0.
- R8: A channel whose pulse-select bit is 1 has `pad_oe` forced to 1 whatever its direction bit holds. It drives 0 outside a pulse whatever its output value bit holds.
- R9: The set of pulsing channels is captured at the start command. A channel selected during a running pulse stays low until the next start. It then pulses together with the others.
- R10: Only channels 7..0 are pulse-capable. Pulse-select bits above bit 7 are not stored and read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | 24 | Pin input levels |
| pad_out | output | 24 | Pin output levels |
| pad_oe | output | 24 | Pin output enables, 1 = drive |

## Verification
The assertions take for granted that `pad_in` changes only between clock edges. This lets the resynchroniser's output be compared with the input two samples earlier. The bench changes `pad_in` on falling edges only.

The assertions also assume that every write is a single-cycle strobe with stable address and data. Under that assumption, a start command is one clean request per write. The bench tasks raise `bus_we` for exactly one cycle, with address and data held from falling edge to falling edge.

The pulse-length checks assume a start is issued only with a length that has already been written. The bench always writes the length before the start and never writes both in the same cycle.

// File: rtl/gpio_pulse_pkg.sv
package gpio_pulse_pkg;

    localparam int unsigned REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        REG_DIR = 3'd0,
        REG_OUT = 3'd1,
        REG_IN  = 3'd2,
        REG_SEL = 3'd3,
        REG_LEN = 3'd4,
        REG_CMD = 3'd5
    } reg_addr_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d        = q;
        d.meta   = async_i;
        d.stable = q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sync_o = q.stable;

endmodule

// File: rtl/gpio_pulse_gen.sv
module gpio_pulse_gen #(
    parameter int unsigned LEN_W = 20,
    parameter int unsigned NP    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [NP-1:0]    sel_i,
    output logic             busy_o,
    output logic [NP-1:0]    fire_o,
    output logic [LEN_W-1:0] cnt_o
);

    typedef struct packed {
        logic [LEN_W-1:0] cnt;
        logic [NP-1:0]    run;
    } pg_t;

    pg_t d, q;

    always_comb begin
        d = q;
        if (q.cnt != '0) begin
            d.cnt = q.cnt - 1'b1;
        end else if (start_i) begin
            d.cnt = len_i;
            d.run = sel_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o = (q.cnt != '0);
    assign fire_o = busy_o ? q.run : '0;
    assign cnt_o  = q.cnt;

endmodule

// File: rtl/gpio_pulse24.sv
module gpio_pulse24
    import gpio_pulse_pkg::*;
#(
    parameter int unsigned NCH    = 24,
    parameter int unsigned NPULSE = 8,
    parameter int unsigned LEN_W  = 20,
    parameter int unsigned DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NCH-1:0]    pad_in,
    output logic [NCH-1:0]    pad_out,
    output logic [NCH-1:0]    pad_oe
);

    typedef struct packed {
        logic [NCH-1:0]    dir;
        logic [NCH-1:0]    outv;
        logic [NPULSE-1:0] sel;
        logic [LEN_W-1:0]  len;
    } regs_t;

    regs_t d, q;

    logic                start_cmd;
    logic                pulse_busy;
    logic [NPULSE-1:0]   pulse_fire;
    logic [LEN_W-1:0]    pulse_cnt;
    logic [NCH-1:0]      in_sync;
    logic [LEN_W-1:0]    len_w;
    logic [NPULSE-1:0]   sel_w;

    assign start_cmd = bus_we && (bus_addr == REG_CMD) && bus_wdata[0];
    assign len_w     = q.len;
    assign sel_w     = q.sel;

    always_comb begin
        d = q;
        if (bus_we) begin
            case (bus_addr)
                REG_DIR: d.dir  = bus_wdata[NCH-1:0];
                REG_OUT: d.outv = bus_wdata[NCH-1:0];
                REG_SEL: d.sel  = bus_wdata[NPULSE-1:0];
                REG_LEN: d.len  = bus_wdata[LEN_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    gpio_in_sync #(.W(NCH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_in),
        .sync_o  (in_sync)
    );

    gpio_pulse_gen #(.LEN_W(LEN_W), .NP(NPULSE)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_cmd),
        .len_i   (q.len),
        .sel_i   (q.sel),
        .busy_o  (pulse_busy),
        .fire_o  (pulse_fire),
        .cnt_o   (pulse_cnt)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_pad
        if (i < NPULSE) begin : g_pulse_ch
            assign pad_oe[i]  = q.sel[i] | q.dir[i];
            assign pad_out[i] = q.sel[i] ? pulse_fire[i] : q.outv[i];
        end else begin : g_plain_ch
            assign pad_oe[i]  = q.dir[i];
            assign pad_out[i] = q.outv[i];
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_DIR: bus_rdata = DW'(q.dir);
            REG_OUT: bus_rdata = DW'(q.outv);
            REG_IN:  bus_rdata = DW'(in_sync);
            REG_SEL: bus_rdata = DW'(q.sel);
            REG_LEN: bus_rdata = DW'(q.len);
            REG_CMD: bus_rdata = DW'(pulse_busy);
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_pulse24_chk.sv
module gpio_pulse24_chk #(
    parameter int unsigned NCH    = 24,
    parameter int unsigned NPULSE = 8,
    parameter int unsigned LEN_W  = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_cmd,
    input logic              busy,
    input logic [LEN_W-1:0]  cnt,
    input logic [LEN_W-1:0]  len,
    input logic [NPULSE-1:0] sel,
    input logic [NPULSE-1:0] fire,
    input logic [NCH-1:0]    pad_out,
    input logic [NCH-1:0]    pad_oe,
    input logic [NCH-1:0]    pad_in,
    input logic [NCH-1:0]    in_sync
);

    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              age_q <= 2'd0;
        else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
    end

    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_cmd && !busy && (len != '0) |=> busy && (cnt == $past(len)));

    p_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ((pad_out[NPULSE-1:0] & sel & fire) == (sel & fire)));

    p_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_cmd && busy |=> (cnt == LEN_W'($past(cnt) - 1'b1)));

    p_zero_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_cmd && !busy && (len == '0) |=> !busy);

    p_forced_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe[NPULSE-1:0] & sel) == sel);

    p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ((pad_out[NPULSE-1:0] & sel) == '0));

    p_sync_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (in_sync == $past(pad_in, 2)));

endmodule

bind gpio_pulse24 gpio_pulse24_chk #(
    .NCH(NCH), .NPULSE(NPULSE), .LEN_W(LEN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_cmd (start_cmd),
    .busy      (pulse_busy),
    .cnt       (pulse_cnt),
    .len       (len_w),
    .sel       (sel_w),
    .fire      (pulse_fire),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_in    (pad_in),
    .in_sync   (in_sync)
);

// File: tb/sim_gpio_pulse24.sv
`timescale 1ns/1ps
module sim_gpio_pulse24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [23:0] pad_in = '0;
    logic [23:0] pad_out;
    logic [23:0] pad_oe;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    gpio_pulse24 u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R1 oe", 32'(pad_oe), 0);
        chk("R1 out", 32'(pad_out), 0);
        for (int a = 0; a < 6; a++) begin
            if (a != 2) begin
                rd(3'(a), v);
                chk("R1 reg", v, 0);
            end
        end
    endtask

    task automatic t_dir_out;
        logic [31:0] v;
        wr(3'd0, 32'h00A50F3C);
        wr(3'd1, 32'h00FF0F00);
        chk("R2 oe", 32'(pad_oe), 32'h00A50F3C);
        chk("R2 out", 32'(pad_out), 32'h00FF0F00);
        rd(3'd0, v); chk("R2 dir rb", v, 32'h00A50F3C);
        rd(3'd1, v); chk("R2 out rb", v, 32'h00FF0F00);
        wr(3'd0, 32'h005AF0C3);
        wr(3'd1, 32'h0000F0FF);
        chk("R2 oe b", 32'(pad_oe), 32'h005AF0C3);
        chk("R2 out b", 32'(pad_out), 32'h0000F0FF);
    endtask

    task automatic t_sync;
        logic [31:0] v;
        foreach (pad_in[i]) ;
        for (int p = 0; p < 2; p++) begin
            logic [23:0] prev, nxt;
            prev = pad_in;
            nxt  = (p == 0) ? 24'h123456 : 24'hFEDCBA;
            @(negedge clk);
            pad_in = nxt;
            @(negedge clk);
            rd(3'd2, v); chk("R3 one edge", v, 32'(prev));
            @(negedge clk);
            rd(3'd2, v); chk("R3 two edges", v, 32'(nxt));
        end
    endtask

    task automatic t_pulse;
        logic [31:0] v;
        wr(3'd0, 32'h000000A5);
        wr(3'd1, 32'h000000FF);
        wr(3'd3, 32'h0000005A);
        chk("R8 oe forced", 32'(pad_oe[7:0]), 32'hFF);
        chk("R8 idle low", 32'(pad_out[7:0]), 32'hA5);
        wr(3'd4, 32'd5);
        wr(3'd5, 32'd1);
        for (int k = 1; k <= 5; k++) begin
            if (k > 1) @(negedge clk);
            chk("R4/R5 high", 32'(pad_out[7:0]), 32'hFF);
            rd(3'd5, v); chk("R4 busy", v, 1);
        end
        @(negedge clk);
        chk("R4 end", 32'(pad_out[7:0]), 32'hA5);
        rd(3'd5, v); chk("R4 idle", v, 0);
    endtask

    task automatic t_len1;
        wr(3'd4, 32'd1);
        wr(3'd5, 32'd1);
        chk("R4 len1 high", 32'(pad_out[7:0]), 32'hFF);
        @(negedge clk);
        chk("R4 len1 low", 32'(pad_out[7:0]), 32'hA5);
    endtask

    task automatic t_zero;
        logic [31:0] v;
        wr(3'd3, 32'hFF);
        wr(3'd4, 32'd0);
        wr(3'd5, 32'd1);
        for (int k = 0; k < 3; k++) begin
            chk("R7 no pulse", 32'(pad_out[7:0]), 0);
            rd(3'd5, v); chk("R7 busy", v, 0);
            @(negedge clk);
        end
    endtask

    task automatic t_restart;
        logic [31:0] v;
        wr(3'd0, 0); wr(3'd1, 0);
        wr(3'd3, 32'h0F);
        wr(3'd4, 32'd8);
        wr(3'd5, 32'd1);
        chk("R6 s1", 32'(pad_out[7:0]), 32'h0F);
        @(negedge clk); @(negedge clk);
        chk("R6 s3", 32'(pad_out[7:0]), 32'h0F);
        wr(3'd4, 32'd2);
        wr(3'd5, 32'd1);
        chk("R6 s7", 32'(pad_out[7:0]), 32'h0F);
        @(negedge clk);
        chk("R6 s8", 32'(pad_out[7:0]), 32'h0F);
        @(negedge clk);
        chk("R6 s9 ended", 32'(pad_out[7:0]), 0);
        rd(3'd5, v); chk("R6 busy clear", v, 0);
        wr(3'd5, 32'd1);
        chk("R6 new len", 32'(pad_out[7:0]), 32'h0F);
        @(negedge clk);
        chk("R6 new len 2", 32'(pad_out[7:0]), 32'h0F);
        @(negedge clk);
        chk("R6 new end", 32'(pad_out[7:0]), 0);
    endtask

    task automatic t_mask_mid;
        wr(3'd3, 32'h01);
        wr(3'd4, 32'd6);
        wr(3'd5, 32'd1);
        chk("R9 s1", 32'(pad_out[7:0]), 32'h01);
        wr(3'd3, 32'h09);
        chk("R9 new ch low", 32'(pad_out[7:0]), 32'h01);
        chk("R9 new ch oe", 32'(pad_oe[3]), 1);
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk("R9 s6", 32'(pad_out[7:0]), 32'h01);
        @(negedge clk);
        chk("R9 s7", 32'(pad_out[7:0]), 0);
        wr(3'd5, 32'd1);
        chk("R9 both", 32'(pad_out[7:0]), 32'h09);
        for (int k = 0; k < 6; k++) @(negedge clk);
        chk("R9 both end", 32'(pad_out[7:0]), 0);
    endtask

    task automatic t_upper;
        logic [31:0] v;
        wr(3'd0, 0);
        wr(3'd3, 32'hFFFFFF00);
        rd(3'd3, v); chk("R10 sel rb", v, 0);
        chk("R10 oe", 32'(pad_oe), 0);
        wr(3'd4, 32'd3);
        wr(3'd5, 32'd1);
        chk("R10 no pulse", 32'(pad_out), 0);
        for (int k = 0; k < 3; k++) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dir_out();
        t_sync();
        t_pulse();
        t_len1();
        t_zero();
        t_restart();
        t_mask_mid();
        t_upper();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule